// File: doc/BRIEF.md
# Drive Register Access Sequencer

This block carries out one programmed-I/O access to a drive register over a 16-bit parallel drive bus. The bus has active-low chip selects, separate active-low read and write strobes, a 3-bit register address and a data bus whose output side is gated by an enable. A single request starts either a write or a read. Each access runs through three timed phases: address setup, strobe active and hold. A read returns the captured data word, and every access ends with a one-cycle completion pulse. On a separate request the block drives a timed active-low reset pulse to the drive.

The drive has sixteen registers split across two chip selects. Only the primary bank is used here, so the secondary select is held inactive. The setup, strobe and hold lengths and the reset pulse length are parameters counted in clock cycles. Each has a minimum of one. The strobe phase is stretched for as long as the drive holds its ready line low.

Top module: `pio_reg_cycle`

## Requirements
- R1: While `rst_n` is low and after its release, `cs_pri_n`, `cs_sec_n`, `rd_n`, `wr_n` and `drv_rst_n` are high, `dd_oe`, `busy` and `done` are low.
- R2: A write accepted at a clock edge pulls `cs_pri_n` low from the next cycle for SETUP_CYC+STROBE_CYC+HOLD_CYC cycles; `wr_n` is low for STROBE_CYC cycles starting SETUP_CYC cycles after `cs_pri_n` falls (with `ready` high).
- R3: In a write, `cs_pri_n` falls at least one cycle before `wr_n` falls, and `wr_n` rises at least one cycle before `cs_pri_n` rises.
- R4: A read pulls `cs_pri_n` low for SETUP_CYC+STROBE_CYC cycles with `rd_n` low for the last STROBE_CYC of them; `rd_n` and `cs_pri_n` rise on the same edge, followed by HOLD_CYC idle-bus cycles before completion.
- R5: `dd_oe` is high exactly while `cs_pri_n` is low in a write, and `dd_out` then equals the write data. `dd_oe` is never high during a read, and never together with a low `rd_n`.
- R6: `da` equals the request address for every cycle in which `cs_pri_n` is low. `cs_sec_n` is never low, and `rd_n` and `wr_n` are never low together.
- R7: After a read, `rd_data` holds the value `dd_in` had in the last cycle in which `rd_n` was low.
- R8: While `ready` is low at the end of the strobe phase, the strobe stays low. If `ready` is low for K ≥ STROBE_CYC cycles from the first strobe cycle, the strobe lasts K+1 cycles.
- R9: `done` is high for exactly one cycle, namely the first cycle after the hold phase (or after the reset pulse), and in that same cycle `busy` is low.
- R10: A reset request holds `drv_rst_n` low for RST_CYC cycles from the cycle after acceptance, with all selects and strobes high and `dd_oe` low; `done` follows.
- R11: Requests that arrive while `busy` is high are ignored. When `rst_req` and `req_valid` are both high in an idle cycle, only the reset pulse runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a register access (accepted while idle) |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 3 | Drive register address |
| req_wdata | input | 16 | Data for a write |
| rst_req | input | 1 | Start a drive reset pulse (wins over req_valid) |
| ready | input | 1 | Drive ready; low stretches the strobe |
| dd_in | input | 16 | Data bus as seen from the drive |
| busy | output | 1 | Access or reset pulse in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word captured by the last read |
| cs_pri_n | output | 1 | Primary bank chip select, active low |
| cs_sec_n | output | 1 | Secondary bank chip select, held high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| da | output | 3 | Drive register address lines |
| dd_out | output | 16 | Data driven toward the drive |
| dd_oe | output | 1 | Output enable for dd_out |
| drv_rst_n | output | 1 | Drive reset, active low |

## Verification
The assertions assume that `ready` is a clean synchronous level that does not stay low forever during a strobe. They also assume that requests arriving while `busy` is high carry no obligation. The stimulus changes every input only on the falling clock edge. It releases `ready` a bounded number of cycles after lowering it, and it deliberately raises requests mid-access to show they have no effect. During reads, `dd_in` is given a different value in every cycle, so the captured word shows exactly which edge sampled it.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_RESET  = 3'd4
  } phase_t;

  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic wr_n;
    logic oe;
    logic drst_n;
  } pins_t;

  localparam pins_t PINS_QUIET = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0, drst_n: 1'b1};

  // Bus pin levels for a given phase and access direction.
  function automatic pins_t phase_pins(phase_t ph, logic is_wr);
    pins_t p;
    p = PINS_QUIET;
    case (ph)
      ST_SETUP: begin
        p.cs_n = 1'b0;
        p.oe   = is_wr;
      end
      ST_STROBE: begin
        p.cs_n = 1'b0;
        p.rd_n = is_wr;
        p.wr_n = ~is_wr;
        p.oe   = is_wr;
      end
      ST_HOLD: begin
        // write keeps the select through hold; read releases with the strobe
        p.cs_n = ~is_wr;
        p.oe   = is_wr;
      end
      ST_RESET: p.drst_n = 1'b0;
      default: p = PINS_QUIET;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/pio_seq.sv
module pio_seq
  import pio_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 2,
  parameter int RST_CYC    = 5
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   rst_req,
  input  logic   ready,
  output phase_t phase_d,
  output logic   accept,
  output logic   cap_en,
  output logic   busy,
  output logic   done
);

  localparam int MAX_A  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_B  = (HOLD_CYC > RST_CYC) ? HOLD_CYC : RST_CYC;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  phase_t        phase_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    cap_en  = 1'b0;
    done_d  = 1'b0;
    case (phase_q)
      ST_IDLE: begin
        if (rst_req) begin
          phase_d = ST_RESET;
          cnt_d   = CW'(RST_CYC - 1);
        end else if (req_valid) begin
          accept  = 1'b1;
          phase_d = ST_SETUP;
          cnt_d   = CW'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (cnt_zero) begin
          phase_d = ST_STROBE;
          cnt_d   = CW'(STROBE_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_STROBE: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - 1'b1;
        end else if (ready) begin
          cap_en  = 1'b1;
          phase_d = ST_HOLD;
          cnt_d   = CW'(HOLD_CYC - 1);
        end
      end
      ST_HOLD, ST_RESET: begin
        if (cnt_zero) begin
          phase_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy = (phase_q != ST_IDLE);
  assign done = done_q;

  a_r8_ready_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_STROBE && !ready) |=> (phase_q == ST_STROBE));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase_q != ST_HOLD && phase_q != ST_RESET) |=> busy);

  initial begin
    a_r2_min_lengths: assert (SETUP_CYC >= 1 && STROBE_CYC >= 1 && HOLD_CYC >= 1 && RST_CYC >= 1);
  end

endmodule

// File: rtl/pio_drive.sv
module pio_drive
  import pio_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        phase_d,
  input  logic          accept,
  input  logic          cap_en,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] dd_in,
  output logic          cs_pri_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          dd_oe,
  output logic          drv_rst_n,
  output logic [AW-1:0] da,
  output logic [DW-1:0] dd_out,
  output logic [DW-1:0] rd_data
);

  pins_t         pins_q;
  logic          wr_q, wr_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, rdat_q;

  assign wr_d = accept ? req_write : wr_q;

  // Request latch: loaded only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
    end else if (accept) begin
      wr_q   <= req_write;
      addr_q <= req_addr;
      wdat_q <= req_wdata;
    end
  end

  // Pins registered from the next phase so strobes come straight off flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= PINS_QUIET;
    else        pins_q <= phase_pins(phase_d, wr_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rdat_q <= '0;
    else if (cap_en && !wr_q) rdat_q <= dd_in;
  end

  assign cs_pri_n  = pins_q.cs_n;
  assign rd_n      = pins_q.rd_n;
  assign wr_n      = pins_q.wr_n;
  assign dd_oe     = pins_q.oe;
  assign drv_rst_n = pins_q.drst_n;
  assign da        = addr_q;
  assign dd_out    = wdat_q;
  assign rd_data   = rdat_q;

  a_r3_cs_leads_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> !$past(cs_pri_n));

  a_r3_wr_leads_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_pri_n) && $past(dd_oe)) |-> $past(wr_n));

  a_r5_oe_not_read: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe |-> rd_n);

  a_r5_wr_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> dd_oe);

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_pri_n && !$past(cs_pri_n)) |-> $stable(da));

  a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_rst_n |-> (cs_pri_n && rd_n && wr_n && !dd_oe));

endmodule

// File: rtl/pio_reg_cycle.sv
module pio_reg_cycle
  import pio_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 2,
  parameter int RST_CYC    = 5,
  parameter int AW         = 3,
  parameter int DW         = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          rst_req,
  input  logic          ready,
  input  logic [DW-1:0] dd_in,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          cs_pri_n,
  output logic          cs_sec_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [AW-1:0] da,
  output logic [DW-1:0] dd_out,
  output logic          dd_oe,
  output logic          drv_rst_n
);

  phase_t phase_d;
  logic   accept, cap_en;

  pio_seq #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .RST_CYC   (RST_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .rst_req  (rst_req),
    .ready    (ready),
    .phase_d  (phase_d),
    .accept   (accept),
    .cap_en   (cap_en),
    .busy     (busy),
    .done     (done)
  );

  pio_drive #(
    .AW(AW),
    .DW(DW)
  ) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_d  (phase_d),
    .accept   (accept),
    .cap_en   (cap_en),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .dd_in    (dd_in),
    .cs_pri_n (cs_pri_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .dd_oe    (dd_oe),
    .drv_rst_n(drv_rst_n),
    .da       (da),
    .dd_out   (dd_out),
    .rd_data  (rd_data)
  );

  // Only the primary register bank is ever addressed.
  assign cs_sec_n = 1'b1;

  a_r6_sec_idle: assert property (@(posedge clk) disable iff (!rst_n) cs_sec_n);

endmodule

// File: tb/pio_reg_cycle_bench.sv
`timescale 1ns/1ps
module pio_reg_cycle_bench;

  localparam int SU = 2, ST = 3, HO = 2, RC = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, rst_req, ready;
  logic [2:0]  req_addr;
  logic [15:0] req_wdata, dd_in;
  logic        busy, done, cs_pri_n, cs_sec_n, rd_n, wr_n, dd_oe, drv_rst_n;
  logic [15:0] rd_data, dd_out;
  logic [2:0]  da;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pio_reg_cycle #(.SETUP_CYC(SU), .STROBE_CYC(ST), .HOLD_CYC(HO), .RST_CYC(RC)) u_pio_reg_cycle (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rst_req(rst_req), .ready(ready),
    .dd_in(dd_in), .busy(busy), .done(done), .rd_data(rd_data),
    .cs_pri_n(cs_pri_n), .cs_sec_n(cs_sec_n), .rd_n(rd_n), .wr_n(wr_n), .da(da),
    .dd_out(dd_out), .dd_oe(dd_oe), .drv_rst_n(drv_rst_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-access trace, cycle 0 = request cycle.
  int cs_first, cs_last, st_first, st_last, oe_first, oe_last, oe_cnt;
  int rst_first, rst_last, done_cyc, da_bad, dout_bad, sec_low, quiet_bad;
  logic [15:0] last_rd_val;

  task automatic run_access(input bit rstq, input bit vld, input bit wr, input logic [2:0] a,
                            input logic [15:0] d, input int rdy_from, input int rdy_len,
                            input bit poke_busy);
    cs_first = -1; cs_last = -1; st_first = -1; st_last = -1;
    oe_first = -1; oe_last = -1; oe_cnt = 0; rst_first = -1; rst_last = -1;
    done_cyc = -1; da_bad = 0; dout_bad = 0; sec_low = 0; quiet_bad = 0; last_rd_val = '0;
    @(negedge clk);
    rst_req = rstq; req_valid = vld; req_write = wr; req_addr = a; req_wdata = d;
    for (int c = 1; c < 60; c++) begin
      @(negedge clk);
      rst_req = 1'b0;
      req_valid = 1'b0;
      if (poke_busy && c == 2) begin
        req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~d; rst_req = 1'b1;
      end
      ready = !(c >= rdy_from && c < rdy_from + rdy_len);
      dd_in = 16'hA000 + 16'(c);
      if (!cs_pri_n) begin
        if (cs_first < 0) cs_first = c;
        cs_last = c;
        if (da != a) da_bad++;
      end
      if (!(wr ? wr_n : rd_n)) begin
        if (st_first < 0) st_first = c;
        st_last = c;
        if (!wr) last_rd_val = dd_in;
      end
      if (dd_oe) begin
        if (oe_first < 0) oe_first = c;
        oe_last = c; oe_cnt++;
        if (dd_out != d) dout_bad++;
      end
      if (!drv_rst_n) begin
        if (rst_first < 0) rst_first = c;
        rst_last = c;
        if (!cs_pri_n || !rd_n || !wr_n || dd_oe) quiet_bad++;
      end
      if (!cs_sec_n) sec_low++;
      if (done && done_cyc < 0) begin
        done_cyc = c;
        if (busy) quiet_bad++;
      end
      if (done_cyc >= 0 && c > done_cyc + 3) break;
      if (c > done_cyc && done_cyc >= 0 && (done || busy || !cs_pri_n)) quiet_bad++;
    end
    ready = 1'b1;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(cs_pri_n && cs_sec_n && rd_n && wr_n && drv_rst_n, "R1 pins idle", {cs_pri_n, rd_n, wr_n, drv_rst_n}, 4'hF);
    chk(!dd_oe && !busy && !done, "R1 oe/busy/done low", {dd_oe, busy, done}, 0);
  endtask

  task automatic t_write(input logic [2:0] a, input logic [15:0] d);
    run_access(0, 1, 1, a, d, 99, 0, 0);
    chk(cs_first == 1 && cs_last == SU+ST+HO, "R2 write cs window", cs_last, SU+ST+HO);
    chk(st_first == 1+SU && st_last == SU+ST, "R2 write strobe window", st_first, 1+SU);
    chk(st_first > cs_first && st_last < cs_last, "R3 write ordering", st_last, cs_last-1);
    chk(oe_first == cs_first && oe_last == cs_last && dout_bad == 0, "R5 oe window/data", oe_last, cs_last);
    chk(da_bad == 0 && sec_low == 0, "R6 address/secondary", da_bad, 0);
    chk(done_cyc == SU+ST+HO+1 && quiet_bad == 0, "R9 write done", done_cyc, SU+ST+HO+1);
  endtask

  task automatic t_read(input logic [2:0] a, input int rdy_len);
    int exp_st;
    exp_st = (rdy_len >= ST) ? rdy_len + 1 : ST;
    run_access(0, 1, 0, a, 16'h0000, 1+SU, rdy_len, 0);
    chk(st_first == 1+SU && st_last - st_first + 1 == exp_st, "R8 read strobe length", st_last-st_first+1, exp_st);
    chk(cs_first == 1 && cs_last == st_last, "R4 rd and cs rise together", cs_last, st_last);
    chk(oe_cnt == 0, "R5 no oe in read", oe_cnt, 0);
    chk(rd_data == last_rd_val, "R7 read data", rd_data, last_rd_val);
    chk(da_bad == 0 && sec_low == 0, "R6 read address", da_bad, 0);
    chk(done_cyc == st_last + HO + 1 && quiet_bad == 0, "R4 R9 read hold then done", done_cyc, st_last+HO+1);
  endtask

  task automatic t_drive_reset(input bit with_req);
    run_access(1, with_req, 1, 3'd5, 16'hBEEF, 99, 0, 0);
    chk(rst_first == 1 && rst_last == RC, "R10 reset pulse length", rst_last, RC);
    chk(quiet_bad == 0 && cs_first < 0 && oe_cnt == 0, "R10 R11 quiet during reset", cs_first, -1);
    chk(done_cyc == RC+1, "R10 done after reset", done_cyc, RC+1);
  endtask

  task automatic t_busy_ignore();
    run_access(0, 1, 1, 3'd2, 16'h1357, 99, 0, 1);
    chk(cs_last == SU+ST+HO && rst_first < 0, "R11 mid-access requests ignored", cs_last, SU+ST+HO);
    chk(da_bad == 0 && dout_bad == 0 && quiet_bad == 0, "R11 no disturbance", da_bad + dout_bad + quiet_bad, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; rst_req = 0; ready = 1;
    req_addr = '0; req_wdata = '0; dd_in = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_reset_state();
    t_write(3'd3, 16'h1234);
    t_write(3'd7, 16'h00A5);
    t_read(3'd7, 0);
    t_read(3'd1, 5);
    t_read(3'd6, 1);
    t_drive_reset(0);
    t_drive_reset(1);
    t_busy_ignore();
    t_write(3'd0, 16'hFFFF);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule